// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small 8-bit accumulator machine whose control comes from a constant microcode table instead of a hand-written state machine. The table is indexed by the 3-bit opcode held in the instruction register and a 2-bit micro-step. Each 14-bit microword does two jobs. It names the step to use on the next clock, and it drives the datapath: the address source, the memory strobes, the ALU function, the accumulator load and the instruction capture.

Step 0 of every routine is the same shared fetch word. It reads the word at the program counter, captures its low three bits as the opcode and moves to step 1 of that opcode's routine. Every instruction occupies two memory words, an opcode word followed by an operand word. The core talks to a single-port memory with combinational read data. It reports the accumulator value and a sticky halted flag, which is set once the stop instruction has run.

Top module: `ucpu_core`

## Requirements
- R1: While reset is high and after it is released, PC, accumulator, instruction register, step and halted are all zero. The first cycle after reset reads address 0 with the read strobe high and the write strobe low.
- R2: A fetch cycle reads memory at the PC, captures the low 3 bits of the read word as the opcode and advances the PC by one. For the program 0:0, 1:3, 2:1, 3:5, 4:2 the addresses in the first five cycles are 0, 1, 2, 3, 4.
- R3: Opcode 0 (load) copies the operand word into the accumulator. Fetch plus execute takes 2 cycles.
- R4: Opcode 1 (add) sets the accumulator to accumulator plus operand, modulo 256, in 2 cycles. Running the example program of R2 leaves 8.
- R5: Opcode 3 (and) sets the accumulator to the bitwise AND of the accumulator and the operand, in 2 cycles.
- R6: Opcode 4 (zero) clears the accumulator whatever the operand holds. It takes 3 cycles, and the operand word is read and skipped.
- R7: Opcode 5 (subtract) sets the accumulator to accumulator minus operand, modulo 256, in 2 cycles.
- R8: Opcode 6 (store) treats its operand as an address. In its third cycle it asserts the write strobe with the read strobe low, drives that address and puts the accumulator on the write data. The accumulator is unchanged.
- R9: Opcode 2 (stop) sets the halted output in the cycle after its execute step. Halted then stays high until reset. While halted, the read and write strobes stay low and the accumulator holds its value.
- R10: Opcode 7 (reserved) reads and skips its operand word and leaves the accumulator unchanged, in 2 cycles.
- R11: Read and write strobes are never high together. Whenever the write strobe is high, the write data equals the accumulator output.
- R12: Only bits 2:0 of an opcode word select the routine, so the word 0x09 behaves as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Memory address: the PC in fetch and operand cycles, the address register otherwise |
| mem_wdata | output | DW | Write data (the accumulator while writing, else zero) |
| mem_rdata | input | DW | Combinational read data from memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | Sticky flag set by the stop instruction |
| acc_out | output | DW | Current accumulator value |

## Verification
Two things can fall in the same cycle. The stop instruction's execute step sets the halted flag, and the memory strobes must go quiet from then on. A halting program is therefore followed by a dozen extra clocks in which any read or write pulse, any change of the accumulator, or a drop of halted is counted as an error.

The second overlap is in the store routine. Its final step drives the address register onto the bus in the cycle right after the PC drove the operand read. The bench samples that exact cycle and judges the address, both strobes and the write data, then checks the written memory word afterwards.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;
  localparam int OP_W   = 3;
  localparam int STEP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LDA = 3'd0,
    OP_ADD = 3'd1,
    OP_HLT = 3'd2,
    OP_AND = 3'd3,
    OP_CLR = 3'd4,
    OP_SUB = 3'd5,
    OP_STA = 3'd6,
    OP_USR = 3'd7
  } op_e;

  // Field order fixes bit positions 13 down to 0.
  typedef struct packed {
    logic [STEP_W-1:0] nxt;
    logic [1:0]        spare;
    logic              use_pc;
    logic              load_mar;
    logic              arith;
    logic              invert;
    logic              pass;
    logic              load_acc;
    logic              acc_to_db;
    logic              rd;
    logic              wr;
    logic              load_ir;
  } uword_t;

  function automatic uword_t ucode_word(input logic [OP_W-1:0] op,
                                        input logic [STEP_W-1:0] stp);
    uword_t w;
    w = '0;
    if (stp == '0) begin
      w.nxt = 2'd1; w.use_pc = 1'b1; w.rd = 1'b1; w.load_ir = 1'b1;
    end else begin
      case (op_e'(op))
        OP_LDA: if (stp == 2'd1) begin
          w.use_pc = 1'b1; w.rd = 1'b1; w.pass = 1'b1; w.load_acc = 1'b1;
        end
        OP_ADD: if (stp == 2'd1) begin
          w.use_pc = 1'b1; w.rd = 1'b1; w.arith = 1'b1; w.load_acc = 1'b1;
        end
        OP_HLT: w.nxt = stp;
        OP_AND: if (stp == 2'd1) begin
          w.use_pc = 1'b1; w.rd = 1'b1; w.load_acc = 1'b1;
        end
        OP_CLR: begin
          if (stp == 2'd1) begin
            w.use_pc = 1'b1; w.rd = 1'b1; w.nxt = 2'd2;
          end else if (stp == 2'd2) begin
            w.load_acc = 1'b1;
          end
        end
        OP_SUB: if (stp == 2'd1) begin
          w.use_pc = 1'b1; w.rd = 1'b1; w.arith = 1'b1; w.invert = 1'b1;
          w.load_acc = 1'b1;
        end
        OP_STA: begin
          if (stp == 2'd1) begin
            w.use_pc = 1'b1; w.rd = 1'b1; w.load_mar = 1'b1; w.nxt = 2'd2;
          end else if (stp == 2'd2) begin
            w.acc_to_db = 1'b1; w.wr = 1'b1;
          end
        end
        default: if (stp == 2'd1) begin
          w.use_pc = 1'b1; w.rd = 1'b1;
        end
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/ucpu_seq.sv
module ucpu_seq
  import ucpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus,
  output uword_t        uw,
  output logic          halted
);
  logic [OP_W-1:0]   ir_q;
  logic [STEP_W-1:0] step_q;
  logic              halted_q;

  always_comb uw = ucode_word(ir_q, step_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q     <= '0;
      step_q   <= '0;
      halted_q <= 1'b0;
    end else begin
      step_q <= uw.nxt;
      if (uw.load_ir) ir_q <= bus[OP_W-1:0];
      if (ir_q == OP_W'(OP_HLT) && step_q != '0) halted_q <= 1'b1;
    end
  end

  assign halted = halted_q;
endmodule

// File: rtl/ucpu_alu.sv
module ucpu_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          arith,
  input  logic          invert,
  input  logic          pass,
  output logic [DW-1:0] y
);
  logic [DW-1:0] b_eff;

  always_comb begin
    b_eff = invert ? ~b : b;
    if (pass)       y = b;
    else if (arith) y = a + b_eff + DW'(invert);
    else            y = a & b_eff;
  end
endmodule

// File: rtl/ucpu_dp.sv
module ucpu_dp
  import ucpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  uword_t        uw,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] bus,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] acc
);
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] acc_q, alu_y;

  assign bus   = uw.rd ? rdata : '0;
  assign addr  = uw.use_pc ? pc_q : mar_q;
  assign wdata = uw.acc_to_db ? acc_q : '0;
  assign acc   = acc_q;

  ucpu_alu #(.DW(DW)) u_alu (
    .a(acc_q), .b(bus), .arith(uw.arith), .invert(uw.invert),
    .pass(uw.pass), .y(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      acc_q <= '0;
    end else begin
      if (uw.use_pc && uw.rd) pc_q <= pc_q + AW'(1);
      if (uw.load_mar)        mar_q <= AW'(bus);
      if (uw.load_acc)        acc_q <= alu_y;
    end
  end
endmodule

// File: rtl/ucpu_core.sv
module ucpu_core
  import ucpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          halted,
  output logic [DW-1:0] acc_out
);
  uword_t        uw;
  logic [DW-1:0] bus;

  ucpu_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .bus(bus), .uw(uw), .halted(halted)
  );

  ucpu_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rst(rst), .uw(uw), .rdata(mem_rdata), .bus(bus),
    .addr(mem_addr), .wdata(mem_wdata), .acc(acc_out)
  );

  assign mem_rd = uw.rd;
  assign mem_wr = uw.wr;
endmodule

// File: rtl/ucpu_core_chk.sv
module ucpu_core_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          halted,
  input logic [DW-1:0] acc_out,
  input logic [AW-1:0] pc,
  input logic [1:0]    step
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11
  AST_WDATA_IS_ACC: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_wdata == acc_out); // R11
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
    (step == 2'd0) |-> (mem_rd && !mem_wr && mem_addr == pc)); // R2
  AST_FETCH_PC_INC: assert property (@(posedge clk) disable iff (rst)
    (step == 2'd0) |=> pc == AW'($past(pc) + 1'b1)); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr)); // R9
  AST_HALT_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(acc_out)); // R9
endmodule

bind ucpu_core ucpu_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted), .acc_out(acc_out),
  .pc(u_dp.pc_q), .step(u_seq.step_q)
);

// File: tb/ucpu_core_tb.sv
module ucpu_core_tb;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int NV = 10;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [15:0] tag;
  } vec_t;

  // Program: 0:LOAD 1:x 2:op 3:y 4:STOP
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'd3,   8'd5,   "R4"},
    '{8'h01, 8'd200, 8'd100, "R4"},
    '{8'h05, 8'd10,  8'd3,   "R7"},
    '{8'h05, 8'd3,   8'd10,  "R7"},
    '{8'h03, 8'hF0,  8'h3C,  "R5"},
    '{8'h04, 8'h5A,  8'hFF,  "R6"},
    '{8'h07, 8'h77,  8'h12,  "R10"},
    '{8'h09, 8'd1,   8'd2,   "R12"},
    '{8'h00, 8'h11,  8'h22,  "R3"},
    '{8'h06, 8'h5C,  8'h40,  "R8"}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_rd, mem_wr, halted;
  logic [DW-1:0] acc_out;
  logic [7:0]    mem [256];
  int            checks = 0;
  int            fails  = 0;

  always #10 clk = ~clk;

  ucpu_core #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .halted(halted), .acc_out(acc_out)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_acc(input logic [7:0] op, x, y);
    case (op[2:0])
      3'd0: return y;
      3'd1: return x + y;
      3'd3: return x & y;
      3'd4: return 8'd0;
      3'd5: return x - y;
      default: return x;
    endcase
  endfunction

  function automatic int exp_cyc(input logic [7:0] op);
    return (op[2:0] == 3'd4 || op[2:0] == 3'd6) ? 3 : 2;
  endfunction

  task automatic load_prog(input logic [7:0] op, x, y);
    for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
    mem[0] = 8'h00; mem[1] = x; mem[2] = op; mem[3] = y; mem[4] = 8'h02;
  endtask

  task automatic release_rst();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic run_to_halt(output int cyc);
    cyc = 0;
    while (!halted && cyc < 60) begin
      @(posedge clk); #1;
      cyc++;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] a0;
    int busy;

    // R1: reset state while reset is held
    load_prog(8'h01, 8'd3, 8'd5);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "acc in reset", acc_out, 0);
    chk("R1", "halted in reset", halted, 0);
    chk("R1", "addr in reset", mem_addr, 0);
    chk("R1", "rd in reset", mem_rd, 1);
    chk("R1", "wr in reset", mem_wr, 0);

    // Vector table: LOAD x, OP y, STOP
    for (int v = 0; v < NV; v++) begin
      load_prog(VECS[v].op, VECS[v].x, VECS[v].y);
      release_rst();
      run_to_halt(cyc);
      chk(string'(VECS[v].tag), "acc result", acc_out,
          exp_acc(VECS[v].op, VECS[v].x, VECS[v].y));
      chk(string'(VECS[v].tag), "cycles to halt", cyc, 4 + exp_cyc(VECS[v].op));
      if (VECS[v].op[2:0] == 3'd6)
        chk("R8", "stored word", mem[VECS[v].y], VECS[v].x);
    end

    // R2: address trace of the example program
    load_prog(8'h01, 8'd3, 8'd5);
    release_rst();
    for (int k = 0; k < 5; k++) begin
      chk("R2", "fetch/operand addr", mem_addr, k);
      chk("R2", "read strobe", mem_rd, 1);
      @(posedge clk); #1;
    end
    run_to_halt(cyc);
    chk("R4", "example program result", acc_out, 8);

    // R8 and R11: store cycle detail
    load_prog(8'h06, 8'h5C, 8'h40);
    release_rst();
    repeat (3) begin @(posedge clk); #1; end
    chk("R8", "operand read addr", mem_addr, 3);
    chk("R8", "operand read strobe", mem_rd, 1);
    @(posedge clk); #1;
    chk("R8", "store addr", mem_addr, 8'h40);
    chk("R8", "store write strobe", mem_wr, 1);
    chk("R11", "no read while writing", mem_rd, 0);
    chk("R11", "write data is acc", mem_wdata, 8'h5C);
    chk("R8", "acc unchanged by store", acc_out, 8'h5C);

    // R9: quiet and stable after halt
    run_to_halt(cyc);
    chk("R9", "halted reached", halted, 1);
    a0 = acc_out;
    busy = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      if (mem_rd || mem_wr || !halted || acc_out !== a0) busy++;
    end
    chk("R9", "activity after halt", busy, 0);

    // R1: reset after halt clears state
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "halted cleared", halted, 0);
    chk("R1", "acc cleared", acc_out, 0);
    chk("R1", "fetch restarts at 0", mem_addr, 0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule